// File: doc/BRIEF.md
# Multidrop UART with Address Tagging

This block is an asynchronous serial transceiver for a shared line with one master and many peripheral stations. Each character carries one extra bit where parity would normally sit. That bit is the address/data tag: 1 marks an address character and 0 marks a data character. No parity is generated or checked. The transmitter sends a frame in this order: a low start bit, 5 to 8 data bits (LSB first), the tag bit, and one or two high stop bits. The tag value comes from a mode-register bit. The mode is captured at the moment a character is loaded.

The receiver watches the line at all times, at 16 samples per bit. When it is enabled, every character is stored in a small receive FIFO. When it is disabled, it stores only characters with an address tag, so a peripheral station can stay quiet until it is addressed. Each FIFO entry holds the data bits and a status slice: the received tag, a framing-error flag and a break flag. A sticky overrun flag reports characters lost to a full FIFO.

Software uses a four-register word interface. Address 0 is the mode register, address 1 is the enables, address 2 is transmit load and receive pop, and address 3 is status and overrun clear. Bit timing comes from a free-running clock-enable divider.

Transmitter states:
- `T_IDLE`: the line is high. It moves to `T_START` when the transmitter is enabled and the holding register is full.
- `T_START`, `T_DATA`, `T_TAG`: the frame bits in order.
- `T_STOP`: sends one stop bit, or two, then returns to `T_IDLE`.

Each transmitter bit lasts 16 ticks.

Receiver states:
- `R_IDLE`: a low sample moves to `R_START`.
- `R_START`: the line is checked again after 8 ticks, at mid-bit. If it is low the receiver goes to `R_DATA`; if it is high again it goes back to `R_IDLE`.
- `R_DATA`: one sample every 16 ticks, then `R_TAG`.
- `R_TAG`: one sample, then `R_STOP`.
- `R_STOP`: samples the first stop bit. If the line is high it returns to `R_IDLE`. If the line is low it goes to `R_WAIT_HIGH`.
- `R_WAIT_HIGH`: stays until the line is high, then returns to `R_IDLE`.

Top module: `mdu_uart`

## Requirements
- R1: After reset, `txd` is 1 and the status register (address 3) reads 8'h02. Status bits: [0] receive data ready, [1] transmit holding register empty, [2] head tag, [3] head framing error, [4] head break, [5] overrun.
- R2: A load written to address 2 sends these bits, each lasting 16 divider ticks: a 0 start bit, then the data LSB first, then the tag, then stop bits at 1. The transmitter must be enabled (address 1 bit 0). The mode register at address 0 sets the frame: bits [1:0] give the data width as 5 + code, bit [2] selects two stop bits, and bit [3] is the tag to send.
- R3: The mode fields are captured when a character is loaded. Rewriting the mode register while that character waits or shifts does not change its frame.
- R4: With the receiver enabled (address 1 bit 1), characters with either tag value are stored. The received tag appears in status bit [2] for the FIFO head.
- R5: With the receiver disabled, a character with tag 0 is dropped and status bit [0] stays 0. A character with tag 1 is stored and sets status bit [0].
- R6: At data widths below 8, the received byte is right-aligned and its upper bits read as 0. The tag is taken from the bit that follows the last data bit.
- R7: A first stop bit sampled low, with at least one data or tag bit high, stores the character with framing-error status bit [3] set and break bit [4] clear.
- R8: A frame in which the data, tag and first stop bit all sample low stores exactly one entry. That entry has data 0 and break bit [4] set. No further entry is stored until the line has returned high. A break is filtered by its tag like any other character, so it is dropped while the receiver is disabled.
- R9: The FIFO holds 4 entries. A character that completes while the FIFO is full is discarded, the earlier entries read back unchanged and in order, and status bit [5] is set. Any write to address 3 clears it.
- R10: With two stop bits selected, the line stays high for the whole second stop bit before the next start bit, even when a second character is already waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 2 | Register select |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Read strobe; at address 2 it pops the FIFO head |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Combinational read data for `cpu_addr` |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The transmitter is checked bit by bit at the centre of each bit. Three frames are used: 8 data bits with tag 1 and two stop bits, a frame with the same width whose mode was rewritten after loading, and 5 data bits with tag 0 and one stop bit. Together they separate width, tag and stop handling, and they show whether configuration is captured at load or read live.

On the receive side, one bench-driven sequence goes through the block under each of these patterns:
- Address and data tags with the receiver enabled, then the same two tags with it disabled. This distinguishes filtering from plain reception.
- A 5-bit character with stray high bits beyond its width.
- A low stop bit with nonzero data, against an all-zero frame that holds the line low for several bit times. This distinguishes a framing error from a break and shows there is a single break entry.
- Five back-to-back characters. These show that a full FIFO keeps its old entries rather than the newest one.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic              brk;
        logic              fe;
        logic              tag;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);

    typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_TAG, T_STOP} tx_state_t;
    typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_TAG, R_STOP, R_WAIT_HIGH} rx_state_t;

    localparam logic [1:0] A_MODE = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;
endpackage

// File: rtl/mdu_baud.sv
module mdu_baud #(
    parameter int DIV = 27
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/mdu_tx.sv
module mdu_tx
    import mdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              load,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_tag,
    input  logic [1:0]        ld_width,
    input  logic              ld_two_stop,
    output logic              txd,
    output logic              ready
);
    tx_state_t         state, state_nx;
    logic              hold_full, hold_tag, hold_two;
    logic [1:0]        hold_width;
    logic [DATA_W-1:0] hold_data, shift;
    logic              stag, stwo;
    logic [2:0]        last_bit, bitn;
    logic [3:0]        tcnt;
    logic              stopn, bit_end;

    assign ready   = !hold_full;
    assign bit_end = tick && (tcnt == 4'd15);

    always_comb begin
        state_nx = state;
        unique case (state)
            T_IDLE:  if (en && hold_full) state_nx = T_START;
            T_START: if (bit_end) state_nx = T_DATA;
            T_DATA:  if (bit_end && bitn == last_bit) state_nx = T_TAG;
            T_TAG:   if (bit_end) state_nx = T_STOP;
            T_STOP:  if (bit_end && !(stwo && !stopn)) state_nx = T_IDLE;
            default: state_nx = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= T_IDLE;
            hold_full  <= 1'b0;
            hold_data  <= '0;
            hold_tag   <= 1'b0;
            hold_two   <= 1'b0;
            hold_width <= '0;
            shift      <= '0;
            stag       <= 1'b0;
            stwo       <= 1'b0;
            last_bit   <= '0;
            bitn       <= '0;
            tcnt       <= '0;
            stopn      <= 1'b0;
        end else begin
            state <= state_nx;
            if (load && !hold_full) begin
                hold_full  <= 1'b1;
                hold_data  <= ld_data;
                hold_tag   <= ld_tag;
                hold_two   <= ld_two_stop;
                hold_width <= ld_width;
            end
            if (state == T_IDLE) begin
                tcnt <= '0;
                if (en && hold_full) begin
                    hold_full <= 1'b0;
                    shift     <= hold_data;
                    stag      <= hold_tag;
                    stwo      <= hold_two;
                    last_bit  <= 3'(hold_width) + 3'd4;
                end
            end else if (tick) begin
                tcnt <= tcnt + 1'b1;
            end
            if (bit_end) begin
                unique case (state)
                    T_START: bitn <= '0;
                    T_DATA: begin
                        bitn  <= bitn + 1'b1;
                        shift <= shift >> 1;
                    end
                    T_TAG:  stopn <= 1'b0;
                    T_STOP: stopn <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (state)
            T_START: txd = 1'b0;
            T_DATA:  txd = shift[0];
            T_TAG:   txd = stag;
            default: txd = 1'b1;
        endcase
    end

    a_r2_hold_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_IDLE && en && hold_full) |=> (state == T_START && !hold_full));
    a_r10_two_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_STOP && stwo && !stopn && bit_end) |=> (state == T_STOP && txd));
endmodule

// File: rtl/mdu_rx.sv
module mdu_rx
    import mdu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] width,
    output logic       done,
    output rx_entry_t  entry
);
    rx_state_t         state, state_nx;
    logic [1:0]        sync;
    logic              rxs, sample;
    logic [3:0]        tcnt;
    logic [2:0]        bitn;
    logic [DATA_W-1:0] dat;
    logic              tagr;

    assign rxs    = sync[1];
    assign sample = tick && (tcnt == 4'd15);

    always_comb begin
        state_nx = state;
        unique case (state)
            R_IDLE:      if (tick && !rxs) state_nx = R_START;
            R_START:     if (tick && tcnt == 4'd7) state_nx = rxs ? R_IDLE : R_DATA;
            R_DATA:      if (sample && bitn == 3'(width) + 3'd4) state_nx = R_TAG;
            R_TAG:       if (sample) state_nx = R_STOP;
            R_STOP:      if (sample) state_nx = rxs ? R_IDLE : R_WAIT_HIGH;
            R_WAIT_HIGH: if (rxs) state_nx = R_IDLE;
            default:     state_nx = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= R_IDLE;
            sync  <= 2'b11;
            tcnt  <= '0;
            bitn  <= '0;
            dat   <= '0;
            tagr  <= 1'b0;
        end else begin
            state <= state_nx;
            sync  <= {sync[0], rxd};
            if (state == R_IDLE) begin
                tcnt <= '0;
                bitn <= '0;
                dat  <= '0;
            end else if (state == R_START && tick && tcnt == 4'd7) begin
                tcnt <= '0;
            end else if (tick) begin
                tcnt <= tcnt + 1'b1;
            end
            if (sample && state == R_DATA) begin
                dat[bitn] <= rxs;
                bitn      <= bitn + 1'b1;
            end
            if (sample && state == R_TAG) tagr <= rxs;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done  <= 1'b0;
            entry <= '0;
        end else begin
            done <= sample && (state == R_STOP);
            if (sample && state == R_STOP) begin
                entry.data <= dat;
                entry.tag  <= tagr;
                entry.fe   <= !rxs;
                entry.brk  <= !rxs && !tagr && (dat == '0);
            end
        end
    end

    a_r8_break_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (done && entry.brk) |-> (entry.data == '0 && entry.fe && !entry.tag));
    a_r8_one_break: assert property (@(posedge clk) disable iff (!rst_n)
        (done && entry.brk) |-> (state == R_WAIT_HIGH));
endmodule

// File: rtl/mdu_fifo.sv
module mdu_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r9_keep_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> ($stable(count) && $stable(wp)));
endmodule

// File: rtl/mdu_uart.sv
module mdu_uart
    import mdu_pkg::*;
#(
    parameter int CLK_DIV    = 27,
    parameter int FIFO_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cpu_addr,
    input  logic       cpu_wr,
    input  logic       cpu_rd,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    input  logic       rxd,
    output logic       txd
);
    logic       tick;
    logic [1:0] m_width;
    logic       m_two, m_tag, tx_en, rx_en, ovr;
    logic       tx_ready, rx_done, push, pop, f_empty, f_full;
    rx_entry_t  rx_ent, head;

    mdu_baud #(.DIV(CLK_DIV)) u_baud (.clk(clk), .rst_n(rst_n), .tick(tick));

    mdu_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(tx_en),
        .load(cpu_wr && cpu_addr == A_DATA), .ld_data(cpu_wdata),
        .ld_tag(m_tag), .ld_width(m_width), .ld_two_stop(m_two),
        .txd(txd), .ready(tx_ready)
    );

    mdu_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .width(m_width),
        .done(rx_done), .entry(rx_ent)
    );

    assign push = rx_done && (rx_en || rx_ent.tag);
    assign pop  = cpu_rd && (cpu_addr == A_DATA);

    mdu_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .din(rx_ent), .dout(head), .empty(f_empty), .full(f_full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_width <= 2'd3;
            m_two   <= 1'b0;
            m_tag   <= 1'b0;
            tx_en   <= 1'b0;
            rx_en   <= 1'b0;
            ovr     <= 1'b0;
        end else begin
            if (cpu_wr && cpu_addr == A_MODE) begin
                m_width <= cpu_wdata[1:0];
                m_two   <= cpu_wdata[2];
                m_tag   <= cpu_wdata[3];
            end
            if (cpu_wr && cpu_addr == A_CTRL) begin
                tx_en <= cpu_wdata[0];
                rx_en <= cpu_wdata[1];
            end
            if (cpu_wr && cpu_addr == A_STAT) ovr <= 1'b0;
            else if (push && f_full)          ovr <= 1'b1;
        end
    end

    always_comb begin
        unique case (cpu_addr)
            A_MODE:  cpu_rdata = {4'b0, m_tag, m_two, m_width};
            A_CTRL:  cpu_rdata = {6'b0, rx_en, tx_en};
            A_DATA:  cpu_rdata = f_empty ? 8'h00 : head.data;
            default: cpu_rdata = {2'b0, ovr,
                                  !f_empty && head.brk, !f_empty && head.fe,
                                  !f_empty && head.tag, tx_ready, !f_empty};
        endcase
    end

    a_r5_disabled_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_en && !rx_ent.tag && !pop) |=> $stable(f_empty));
    a_r9_ovr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && (rx_en || rx_ent.tag) && f_full && !pop && !(cpu_wr && cpu_addr == A_STAT))
        |=> ovr);
endmodule

// File: tb/sim_mdu_uart.sv
`timescale 1ns/1ps
module sim_mdu_uart;
    localparam int DIV = 2;
    localparam int P   = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       rxd = 1'b1;
    logic       txd;
    int         n_chk = 0, n_bad = 0;
    bit         finished = 0;

    always #2.5 clk = ~clk;

    mdu_uart #(.CLK_DIV(DIV), .FIFO_DEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .rxd(rxd), .txd(txd)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    task automatic pop(output logic [7:0] d);
        @(negedge clk);
        cpu_addr = 2'd2; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic cap_frame(input int nb, input int ns, output logic [15:0] f);
        f = '0;
        @(negedge txd);
        repeat (P / 2) @(posedge clk);
        for (int i = 0; i < 2 + nb + ns; i++) begin
            #1 f[i] = txd;
            if (i < 1 + nb + ns) repeat (P) @(posedge clk);
        end
    endtask

    function automatic logic [15:0] exp_frame(input logic [7:0] d, input int nb,
                                              input logic tg, input int ns);
        logic [15:0] f = '0;
        for (int i = 0; i < nb; i++) f[1 + i] = d[i];
        f[1 + nb] = tg;
        for (int i = 0; i < ns; i++) f[2 + nb + i] = 1'b1;
        return f;
    endfunction

    task automatic send(input logic [7:0] d, input int nb, input logic tg,
                        input logic stop, input int low_extra);
        @(negedge clk);
        rxd = 1'b0;
        repeat (P) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            repeat (P) @(negedge clk);
        end
        rxd = tg;
        repeat (P) @(negedge clk);
        rxd = stop;
        repeat (P * (1 + low_extra)) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * P) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] s;
        check("R1 txd idle", int'(txd), 1);
        rd(2'd3, s);
        check("R1 status", int'(s), 8'h02);
    endtask

    task automatic t_tx;
        logic [15:0] f1, f2, f3;
        wr(2'd0, 8'h0F);
        wr(2'd1, 8'h01);
        fork
            cap_frame(8, 2, f1);
            begin
                wr(2'd2, 8'hA5);
                repeat (4) @(negedge clk);
                wr(2'd2, 8'h3C);
                wr(2'd0, 8'h07);
            end
        join
        check("R2 R10 frame 8b tag1 2stop", int'(f1), int'(exp_frame(8'hA5, 8, 1'b1, 2)));
        cap_frame(8, 2, f2);
        check("R3 tag captured at load", int'(f2), int'(exp_frame(8'h3C, 8, 1'b1, 2)));
        wr(2'd0, 8'h00);
        fork
            cap_frame(5, 1, f3);
            wr(2'd2, 8'hEF);
        join
        check("R2 frame 5b tag0 1stop", int'(f3), int'(exp_frame(8'hEF, 5, 1'b0, 1)));
        wr(2'd1, 8'h00);
    endtask

    task automatic t_rx_enabled;
        logic [7:0] s, d;
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h02);
        send(8'h5A, 8, 1'b0, 1'b1, 0);
        send(8'hC3, 8, 1'b1, 1'b1, 0);
        rd(2'd3, s);
        check("R4 head data tag status", int'(s), 8'h03);
        pop(d);
        check("R4 data char", int'(d), 8'h5A);
        rd(2'd3, s);
        check("R4 head address tag status", int'(s), 8'h07);
        pop(d);
        check("R4 address char", int'(d), 8'hC3);
        rd(2'd3, s);
        check("R4 fifo drained", int'(s), 8'h02);
    endtask

    task automatic t_rx_disabled;
        logic [7:0] s, d;
        wr(2'd1, 8'h00);
        send(8'h11, 8, 1'b0, 1'b1, 0);
        rd(2'd3, s);
        check("R5 data tag dropped", int'(s), 8'h02);
        send(8'h22, 8, 1'b1, 1'b1, 0);
        rd(2'd3, s);
        check("R5 address tag kept", int'(s), 8'h07);
        pop(d);
        check("R5 address data", int'(d), 8'h22);
    endtask

    task automatic t_width5;
        logic [7:0] s, d;
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h02);
        send(8'hF5, 5, 1'b1, 1'b1, 0);
        rd(2'd3, s);
        check("R6 5b tag", int'(s), 8'h07);
        pop(d);
        check("R6 5b data right aligned", int'(d), 8'h15);
        wr(2'd0, 8'h03);
    endtask

    task automatic t_framing;
        logic [7:0] s, d;
        send(8'h81, 8, 1'b1, 1'b0, 0);
        rd(2'd3, s);
        check("R7 framing status", int'(s), 8'h0F);
        pop(d);
        check("R7 framing data", int'(d), 8'h81);
    endtask

    task automatic t_break;
        logic [7:0] s, d;
        send(8'h00, 8, 1'b0, 1'b0, 4);
        rd(2'd3, s);
        check("R8 break status", int'(s), 8'h1B);
        pop(d);
        check("R8 break data", int'(d), 8'h00);
        rd(2'd3, s);
        check("R8 single break entry", int'(s), 8'h02);
    endtask

    task automatic t_overrun;
        logic [7:0] s, d;
        for (int i = 1; i <= 5; i++) send(8'(i), 8, 1'b0, 1'b1, 0);
        rd(2'd3, s);
        check("R9 overrun flag", int'(s), 8'h23);
        for (int i = 1; i <= 4; i++) begin
            pop(d);
            check("R9 earlier entries kept", int'(d), i);
        end
        wr(2'd3, 8'h00);
        rd(2'd3, s);
        check("R9 overrun cleared and empty", int'(s), 8'h02);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_tx();
        t_rx_enabled();
        t_rx_disabled();
        t_width5();
        t_framing();
        t_break();
        t_overrun();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule